// File: doc/BRIEF.md
# Thermistor Resistance Tracking Monitor

This block tracks the resistance of an external thermistor network one step per sample period. The pin current source is set by an 8-bit conductance code, where one LSB is 250 nS (one 4 MΩ resistor in parallel) and code 256 would be about 15.625 kΩ. An analog comparator reports whether the pin voltage is above or below a 1.25 V reference. The block moves the code one step toward balance. A larger code means a lower network resistance, so the code rises as the thermistor warms.

The block filters the code along two paths. A fast first-order filter feeds the shutdown compare and the start-up gate. A slow first-order filter drives a linear current-derating scale factor, so that the LED current changes without visible steps. The shutdown fault is latched and only a reset clears it. The ready flag stays low until tracking has had time to settle and the temperature reads below the start-up limit.

Top module: `thermtrk_monitor`

## Requirements
- R1: The code changes only on sample ticks. A tick occurs every SAMPLE_DIV clock cycles, and the first tick is the SAMPLE_DIV-th rising edge after reset is released.
- R2: On a tick, if `cmp_hi` is 1 (pin voltage above the reference) the code decreases by one. If `cmp_hi` is 0 the code increases by one.
- R3: The code saturates. It stays at 0 when asked to go lower and stays at 255 when asked to go higher, with no wraparound.
- R4: Each filter keeps a state s with SH fraction bits. On every tick it updates s ← s + ((code·2^SH − s) >>> SH), using the code value from before that tick's step. The arithmetic shift floors the result. The filter output is s >> SH. The fast filter uses FAST_SH and the slow filter uses SLOW_SH.
- R5: On the clock edge after the fast filter output reaches TRIP_CODE (241, about 16.6 kΩ) or more, `fault` goes to 1. It stays at 1 until reset, whatever the code does afterwards.
- R6: `derate` is registered from the current slow filter output f. It is 255 when f ≤ DERATE_START (197). When DERATE_START < f < TRIP_CODE it is 255 − DERATE_STEP·(f − DERATE_START). At or above TRIP_CODE it is 255 − DERATE_STEP·(TRIP_CODE − DERATE_START), which is 35 at the default values.
- R7: `ready` is registered. It is 1 only when SETTLE_TICKS ticks have elapsed since reset, the fast filter output is below READY_CODE (235, about 17.02 kΩ), and no fault is latched or being latched.
- R8: While `rst_n` is low at a clock edge, the code, both filter states, the tick and settle counters, `fault` and `ready` all clear to 0, and `derate` goes to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cmp_hi | input | 1 | Comparator: 1 when the pin voltage is above the reference |
| code | output | 8 | Conductance code driving the pin current source |
| derate | output | 8 | LED current scale factor, where 255 means full current |
| ready | output | 1 | Start-up permitted |
| fault | output | 1 | Latched overtemperature shutdown |

## Verification
The hardest situation to reach is the part of the derating ramp just below the trip point, where the slow filter sits inside the linear region while the fast filter has not yet latched the fault. The bench makes the comparator follow a moving resistance target taken from the code output. It raises the target one step at a time through the derate and trip band at a rate the reduced filter shifts can follow, so each scale value appears before shutdown. After that, the target is driven far past both ends of the range. This pushes the code against 255 and 0, and shows that the fault stays latched while the temperature falls again.

// File: rtl/thermtrk_pkg.sv
// Package: shared constants for the thermistor tracking monitor.
// Assumes an 8-bit conductance code in which one LSB is 250 nS.
package thermtrk_pkg;
    localparam int CODE_W   = 8;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/thermtrk_tick.sv
// Sample timer and settle counter.
// Emits a one-cycle tick every SAMPLE_DIV clocks. Raises settled once
// SETTLE_TICKS ticks have elapsed since reset. Assumes SAMPLE_DIV >= 1.
module thermtrk_tick #(
    parameter int SAMPLE_DIV   = 125,
    parameter int SETTLE_TICKS = 12000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic settled
);
    localparam int DW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam int SW = $clog2(SETTLE_TICKS + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(SAMPLE_DIV - 1);
    localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_TICKS);

    logic [DW-1:0] div_q;
    logic [SW-1:0] set_q;

    assign tick    = (div_q == DIV_LAST);
    assign settled = (set_q == SET_LAST);

    // Divide the clock down to the sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // Count ticks until the settle window has passed, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 set_q <= '0;
        else if (tick && !settled)  set_q <= set_q + 1'b1;
    end
endmodule

// File: rtl/thermtrk_stepper.sv
// Successive-step tracker: moves the conductance code one LSB per tick
// against the comparator result, saturating at both ends.
module thermtrk_stepper
    import thermtrk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  cmp_hi,
    output code_t code
);
    code_t code_q;
    code_t code_d;

    // Next code: step down when the pin sits high, up otherwise, clamped.
    always_comb begin
        code_d = code_q;
        if (cmp_hi) begin
            if (code_q != '0) code_d = code_q - 1'b1;
        end else begin
            if (code_q != code_t'(CODE_MAX)) code_d = code_q + 1'b1;
        end
    end

    // Hold the code and take the step on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (tick) code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/thermtrk_iir.sv
// First-order IIR low-pass filter with coefficient 2^-SH, updated on tick.
// The state carries SH fraction bits, and the output is the integer part.
// Assumes SH >= 1. The state stays within [0, CODE_MAX << SH].
module thermtrk_iir
    import thermtrk_pkg::*;
#(
    parameter int SH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  code_t x,
    output code_t y
);
    localparam int SW = CODE_W + SH;

    logic        [SW-1:0] st_q;
    logic signed [SW+1:0] diff;
    logic signed [SW+1:0] step;
    logic signed [SW+1:0] sum;

    // Error between the scaled input and the state, shifted by the coefficient.
    always_comb begin
        diff = $signed({2'b00, x, {SH{1'b0}}}) - $signed({2'b00, st_q});
        step = diff >>> SH;
        sum  = $signed({2'b00, st_q}) + step;
    end

    // Accumulate one filter step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= '0;
        else if (tick) st_q <= sum[SW-1:0];
    end

    assign y = st_q[SW-1:SH];
endmodule

// File: rtl/thermtrk_derate.sv
// Maps the slow-filtered code to an LED current scale factor: full scale
// up to START, a linear fall of STEP per code, and a floor at TRIP.
// Assumes STEP * (TRIP - START) <= CODE_MAX.
module thermtrk_derate
    import thermtrk_pkg::*;
#(
    parameter int START = 197,
    parameter int TRIP  = 241,
    parameter int STEP  = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_t level,
    output code_t scale
);
    localparam int FLOOR = CODE_MAX - STEP * (TRIP - START);

    code_t      scale_d;
    logic [15:0] drop;

    // Piecewise-linear scale versus filtered code.
    always_comb begin
        drop = 16'(STEP) * (16'(level) - 16'(START));
        if (level <= code_t'(START))     scale_d = code_t'(CODE_MAX);
        else if (level >= code_t'(TRIP)) scale_d = code_t'(FLOOR);
        else                             scale_d = code_t'(16'(CODE_MAX) - drop);
    end

    // Register the scale so that the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) scale <= code_t'(CODE_MAX);
        else        scale <= scale_d;
    end
endmodule

// File: rtl/thermtrk_monitor.sv
// Top: thermistor resistance tracking monitor.
// Ties together the sample timer, stepper, fast and slow filters, derate map,
// latched shutdown and start-up gate. Assumes rst_n is the power-on reset.
module thermtrk_monitor
    import thermtrk_pkg::*;
#(
    parameter int SAMPLE_DIV   = 125,
    parameter int SETTLE_TICKS = 12000,
    parameter int FAST_SH      = 2,
    parameter int SLOW_SH      = 12,
    parameter int DERATE_START = 197,
    parameter int TRIP_CODE    = 241,
    parameter int READY_CODE   = 235,
    parameter int DERATE_STEP  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_hi,
    output logic [7:0] code,
    output logic [7:0] derate,
    output logic       ready,
    output logic       fault
);
    logic  tick;
    logic  settled;
    code_t code_w;
    code_t fast_y;
    code_t slow_y;
    logic  trip;
    logic  fault_q;
    logic  ready_q;

    thermtrk_tick #(.SAMPLE_DIV(SAMPLE_DIV), .SETTLE_TICKS(SETTLE_TICKS)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick), .settled(settled)
    );

    thermtrk_stepper i_step (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_hi(cmp_hi), .code(code_w)
    );

    thermtrk_iir #(.SH(FAST_SH)) i_fast (
        .clk(clk), .rst_n(rst_n), .tick(tick), .x(code_w), .y(fast_y)
    );

    thermtrk_iir #(.SH(SLOW_SH)) i_slow (
        .clk(clk), .rst_n(rst_n), .tick(tick), .x(code_w), .y(slow_y)
    );

    thermtrk_derate #(.START(DERATE_START), .TRIP(TRIP_CODE), .STEP(DERATE_STEP)) i_der (
        .clk(clk), .rst_n(rst_n), .level(slow_y), .scale(derate)
    );

    assign trip = (fast_y >= code_t'(TRIP_CODE));

    // Latch the shutdown fault, which only reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_q | trip;
    end

    // Gate start-up on settling, temperature and absence of fault.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= settled && (fast_y < code_t'(READY_CODE)) && !(fault_q || trip);
    end

    assign code  = code_w;
    assign fault = fault_q;
    assign ready = ready_q;
endmodule

// File: rtl/thermtrk_chk.sv
// Checker for thermtrk_monitor: temporal properties at the ports.
module thermtrk_chk #(
    parameter int DERATE_START = 197,
    parameter int TRIP_CODE    = 241,
    parameter int DERATE_STEP  = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_hi,
    input logic [7:0] code,
    input logic [7:0] derate,
    input logic       ready,
    input logic       fault
);
    localparam int FLOOR = 255 - DERATE_STEP * (TRIP_CODE - DERATE_START);

    AST_CODE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (code != $past(code)) |-> ((code == $past(code) + 8'd1) || (code == $past(code) - 8'd1))); // R3
    AST_CODE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (code != $past(code)) |-> ($past(cmp_hi) ? (code < $past(code)) : (code > $past(code)))); // R2
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fault) |-> fault); // R5
    AST_READY_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !fault); // R7
    AST_DERATE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(derate) >= FLOOR)); // R6
endmodule

bind thermtrk_monitor thermtrk_chk #(
    .DERATE_START(DERATE_START), .TRIP_CODE(TRIP_CODE), .DERATE_STEP(DERATE_STEP)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .code(code),
    .derate(derate), .ready(ready), .fault(fault)
);

// File: tb/test_thermtrk_monitor.sv
// Bench: a small configuration driven by a resistance target that follows the
// code, compared every cycle against a model built from the requirements.
module test_thermtrk_monitor;
    localparam int DIV = 3, SETT = 6, FSH = 1, SSH = 2;
    localparam int DST = 197, TRP = 241, RDY = 235, STP = 5;

    logic clk = 1'b0, rst_n = 1'b0, cmp_hi = 1'b0;
    logic [7:0] code, derate;
    logic ready, fault;
    int checks = 0, errors = 0, target = 0;
    bit done = 1'b0;

    thermtrk_monitor #(.SAMPLE_DIV(DIV), .SETTLE_TICKS(SETT), .FAST_SH(FSH), .SLOW_SH(SSH),
        .DERATE_START(DST), .TRIP_CODE(TRP), .READY_CODE(RDY), .DERATE_STEP(STP)) i_thermtrk_monitor (
        .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .code(code),
        .derate(derate), .ready(ready), .fault(fault));

    always #4 clk = ~clk;

    // Reference model, following R1..R8.
    int m_div = 0, m_set = 0, m_code = 0, m_fst = 0, m_slw = 0, m_der = 255;
    bit m_fault = 0, m_ready = 0;

    function automatic int der_of(int f);
        if (f <= DST) return 255;
        if (f >= TRP) return 255 - STP * (TRP - DST);
        return 255 - STP * (f - DST);
    endfunction

    always @(posedge clk) begin
        int fo, so, nc;
        bit tk, trip;
        if (!rst_n) begin
            m_div = 0; m_set = 0; m_code = 0; m_fst = 0; m_slw = 0;
            m_der = 255; m_fault = 0; m_ready = 0;
        end else begin
            fo = m_fst >> FSH; so = m_slw >> SSH;
            tk = (m_div == DIV - 1);
            trip = fo >= TRP;
            m_der = der_of(so);
            m_ready = (m_set == SETT) && (fo < RDY) && !(m_fault || trip);
            m_fault = m_fault || trip;
            if (tk) begin
                nc = cmp_hi ? m_code - 1 : m_code + 1;
                if (nc < 0) nc = 0;
                if (nc > 255) nc = 255;
                m_fst = m_fst + (((m_code << FSH) - m_fst) >>> FSH);
                m_slw = m_slw + (((m_code << SSH) - m_slw) >>> SSH);
                m_code = nc;
                if (m_set != SETT) m_set = m_set + 1;
                m_div = 0;
            end else m_div = m_div + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1 R2 R3 code", int'(code), m_code);
        chk("R4 R6 derate", int'(derate), m_der);
        chk("R4 R5 fault", int'(fault), int'(m_fault));
        chk("R7 ready", int'(ready), int'(m_ready));
    endtask

    // Run n cycles with the comparator emulating a network at the target code.
    task automatic run(int tgt, int n);
        target = tgt;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            cmp_hi = (int'(code) > target);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state.
        chk("R8 code", int'(code), 0);
        chk("R8 derate", int'(derate), 255);
        chk("R8 fault", int'(fault), 0);
        chk("R8 ready", int'(ready), 0);
        rst_n = 1'b1;
        run(120, 700);                       // cool network: tracking and ready
        chk("R7 ready after settle", int'(ready), 1);
        for (int t = 185; t <= 250; t++) run(t, 30);   // through derate and trip band
        chk("R6 derate at floor", int'(derate), 255 - STP * (TRP - DST));
        run(400, 900);                       // force upper saturation
        chk("R3 code upper saturation", int'(code), 255);
        chk("R5 fault latched", int'(fault), 1);
        run(-10, 900);                       // cool down: fault must persist
        chk("R3 code lower saturation", int'(code), 0);
        chk("R5 fault held after cooling", int'(fault), 1);
        chk("R7 ready held low by fault", int'(ready), 0);
        @(negedge clk); rst_n = 1'b0; cmp_hi = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R8 fault cleared by reset", int'(fault), 0);
        chk("R8 derate after reset", int'(derate), 255);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin   // R3: underflow from reset value
            @(negedge clk);
            check_all();
            cmp_hi = 1'b1;
        end
        chk("R3 code stays at zero", int'(code), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule